// File: doc/BRIEF.md
# Segmented Accumulator Register File

This block holds four 36-bit accumulators, selected by a 2-bit index (0 = A, 1 = B, 2 = C, 3 = D). Each accumulator has three portions: a 4-bit extension in bits 35:32, an upper word in bits 31:16 and a lower word in bits 15:0. The two words together also form a 32-bit long view. A bus port can read or write any portion, a byte, the long view or the whole register. Each access converts the data width, either by sign-extending or by clearing the parts it does not cover.

Three other clients reach the storage, and each is limited to the access it needs:
- A parallel-move port loads and reads whole accumulators only.
- A secondary-read port delivers one word, and that word may land only in C.
- A write-back port takes 36-bit results from the arithmetic unit.

The arithmetic unit reads operands through combinational read ports, so in the cycle of a load it sees the value from before that load. When several clients write the same accumulator in one cycle, a fixed priority decides which write takes effect.

Top module: `acc_regfile`

## Requirements
- R1: After reset, all four accumulators read 0.
- R2: A bus write with part code 4 replaces all 36 bits. Part code 3 writes bits 31:0 from wdata[31:0] and copies bit 31 into bits 35:32.
- R3: A bus write with part code 1 puts wdata[15:0] into bits 31:16, fills bits 35:32 with its sign and clears bits 15:0. Part code 5 puts wdata[7:0] into bits 23:16, fills bits 35:24 with its sign and clears bits 15:0.
- R4: A bus write with part code 0 changes only bits 35:32, taking them from wdata[3:0]. Part code 2 changes only bits 15:0, taking them from wdata[15:0].
- R5: Bus reads of the current value are combinational and right-aligned:
  - code 0 gives bits 35:32, zero-extended;
  - code 1 gives bits 31:16, sign-extended;
  - code 2 gives bits 15:0, zero-extended;
  - code 3 gives bits 31:0, sign-extended;
  - code 4 gives all 36 bits;
  - code 5 gives bits 23:16, sign-extended.
  A write is visible from the cycle after its clock edge.
- R6: Part codes 6 and 7 are rejected. bus_err is 1 in that cycle, no accumulator changes and bus_rdata is 0.
- R7: With special_en low, bus accesses to parts 0 and 2 of C and D are rejected, with the same effect as in R6. With special_en high they are allowed. A and B are never restricted.
- R8: A parallel-move write loads the whole 36-bit value into the selected accumulator. pm_rdata always shows the whole accumulator named by pm_rsel.
- R9: Each arithmetic read port shows the current value of its selected accumulator. In the cycle of a load to that accumulator it still shows the old value.
- R10: A secondary-read write with dr_sel = 2 puts the word into C, with the sign extended and the lower word cleared. Any other dr_sel raises dr_err in that cycle and changes nothing.
- R11: For one accumulator the priority is write-back, then parallel move, then secondary read, then bus. Writes to different accumulators in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| special_en | input | 1 | Allows bus access to the extension and lower word of C and D |
| bus_sel | input | 2 | Bus accumulator index |
| bus_part | input | 3 | Bus part code (see R2 to R6) |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_wdata | input | 36 | Bus write data, right-aligned |
| bus_rdata | output | 36 | Bus read data, right-aligned |
| bus_err | output | 1 | Bus access rejected |
| pm_we | input | 1 | Parallel-move load strobe |
| pm_sel | input | 2 | Parallel-move load target |
| pm_wdata | input | 36 | Parallel-move load value |
| pm_rsel | input | 2 | Parallel-move read index |
| pm_rdata | output | 36 | Parallel-move read value |
| dr_we | input | 1 | Secondary-read write strobe |
| dr_sel | input | 2 | Secondary-read target (only 2 is accepted) |
| dr_wdata | input | 16 | Secondary-read word |
| dr_err | output | 1 | Secondary-read target rejected |
| wb_we | input | 1 | Write-back strobe |
| wb_sel | input | 2 | Write-back target |
| wb_wdata | input | 36 | Write-back value |
| alu_sel | input | 4 | Two 2-bit arithmetic read indices |
| alu_rdata | output | 72 | Two 36-bit arithmetic operands |

## Verification
The assertions check on every cycle that:
- a write-back always lands;
- an unopposed parallel load or secondary-read write lands with the stated format;
- a rejected bus or secondary-read access leaves its target unchanged;
- a rejected read returns zero;
- A and B are never refused.

Only the bench scenarios can show the exact width conversion of each part code on read and write, and the switch from refused to allowed when special_en changes. They also show that an arithmetic read sees the old value in the cycle of a load, and how the priority resolves between two lower-ranked clients.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int EXT_W  = 4;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int LONG_W = 2 * WORD_W;
  localparam int ACC_W  = EXT_W + LONG_W;

  typedef logic [ACC_W-1:0] acc_t;

  typedef enum logic [2:0] {
    PART_EXT  = 3'd0,
    PART_HI   = 3'd1,
    PART_LO   = 3'd2,
    PART_LONG = 3'd3,
    PART_FULL = 3'd4,
    PART_BYTE = 3'd5
  } part_e;

  // New register value after writing data d through the given portion.
  function automatic acc_t merge_write(acc_t old, logic [2:0] part, acc_t d);
    acc_t r;
    case (part)
      PART_EXT:  r = {d[EXT_W-1:0], old[LONG_W-1:0]};
      PART_HI:   r = {{EXT_W{d[WORD_W-1]}}, d[WORD_W-1:0], {WORD_W{1'b0}}};
      PART_LO:   r = {old[ACC_W-1:WORD_W], d[WORD_W-1:0]};
      PART_LONG: r = {{EXT_W{d[LONG_W-1]}}, d[LONG_W-1:0]};
      PART_FULL: r = d;
      PART_BYTE: r = {{(EXT_W+BYTE_W){d[BYTE_W-1]}}, d[BYTE_W-1:0], {WORD_W{1'b0}}};
      default:   r = old;
    endcase
    return r;
  endfunction

  // Right-aligned view of one portion of a register value.
  function automatic acc_t read_view(acc_t v, logic [2:0] part);
    acc_t r;
    case (part)
      PART_EXT:  r = {{(ACC_W-EXT_W){1'b0}}, v[ACC_W-1:LONG_W]};
      PART_HI:   r = {{(ACC_W-WORD_W){v[LONG_W-1]}}, v[LONG_W-1:WORD_W]};
      PART_LO:   r = {{(ACC_W-WORD_W){1'b0}}, v[WORD_W-1:0]};
      PART_LONG: r = {{EXT_W{v[LONG_W-1]}}, v[LONG_W-1:0]};
      PART_FULL: r = v;
      PART_BYTE: r = {{(ACC_W-BYTE_W){v[WORD_W+BYTE_W-1]}}, v[WORD_W+BYTE_W-1:WORD_W]};
      default:   r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/acc_access_ctl.sv
module acc_access_ctl
  import acc_pkg::*;
#(
  parameter int SEL_W         = 2,
  parameter int RESTRICT_FROM = 2,
  parameter int DR_TARGET     = 2
) (
  input  logic [SEL_W-1:0] bus_sel,
  input  logic [2:0]       bus_part,
  input  logic             special_en,
  input  logic [SEL_W-1:0] dr_sel,
  output logic             bus_ok,
  output logic             dr_ok
);
  localparam logic [SEL_W-1:0] RLIM = SEL_W'(RESTRICT_FROM);
  localparam logic [SEL_W-1:0] DRT  = SEL_W'(DR_TARGET);

  logic part_valid;
  logic part_guarded;
  logic sel_guarded;

  assign part_valid   = (bus_part <= PART_BYTE);
  assign part_guarded = (bus_part == PART_EXT) || (bus_part == PART_LO);
  assign sel_guarded  = (bus_sel >= RLIM);
  assign bus_ok       = part_valid && !(part_guarded && sel_guarded && !special_en);
  assign dr_ok        = (dr_sel == DRT);
endmodule

// File: rtl/acc_slot.sv
module acc_slot
  import acc_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_we,
  input  logic [SEL_W-1:0] wb_sel,
  input  acc_t             wb_wdata,
  input  logic             pm_we,
  input  logic [SEL_W-1:0] pm_sel,
  input  acc_t             pm_wdata,
  input  logic             dr_go,
  input  logic [SEL_W-1:0] dr_sel,
  input  logic [WORD_W-1:0] dr_wdata,
  input  logic             bus_go,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic [2:0]       bus_part,
  input  acc_t             bus_wdata,
  output acc_t             q
);
  localparam logic [SEL_W-1:0] MY = SEL_W'(IDX);

  logic wb_hit, pm_hit, dr_hit, bus_hit;
  acc_t nxt;

  assign wb_hit  = wb_we  && (wb_sel  == MY);
  assign pm_hit  = pm_we  && (pm_sel  == MY);
  assign dr_hit  = dr_go  && (dr_sel  == MY);
  assign bus_hit = bus_go && (bus_sel == MY);

  always_comb begin
    nxt = q;
    if (wb_hit)       nxt = wb_wdata;
    else if (pm_hit)  nxt = pm_wdata;
    else if (dr_hit)  nxt = merge_write(q, PART_HI, {{(ACC_W-WORD_W){1'b0}}, dr_wdata});
    else if (bus_hit) nxt = merge_write(q, bus_part, bus_wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/acc_read_mux.sv
module acc_read_mux
  import acc_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_ACC*ACC_W-1:0] acc_flat,
  input  logic [SEL_W-1:0]         sel,
  input  logic [2:0]               part,
  input  logic                     en,
  output acc_t                     rdata
);
  acc_t picked;
  assign picked = acc_flat[sel*ACC_W +: ACC_W];
  assign rdata  = en ? read_view(picked, part) : '0;
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile
  import acc_pkg::*;
#(
  parameter int NUM_ACC    = 4,
  parameter int NUM_ALU_RD = 2,
  parameter int SEL_W      = $clog2(NUM_ACC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        special_en,
  input  logic [SEL_W-1:0]            bus_sel,
  input  logic [2:0]                  bus_part,
  input  logic                        bus_we,
  input  logic                        bus_re,
  input  logic [ACC_W-1:0]            bus_wdata,
  output logic [ACC_W-1:0]            bus_rdata,
  output logic                        bus_err,
  input  logic                        pm_we,
  input  logic [SEL_W-1:0]            pm_sel,
  input  logic [ACC_W-1:0]            pm_wdata,
  input  logic [SEL_W-1:0]            pm_rsel,
  output logic [ACC_W-1:0]            pm_rdata,
  input  logic                        dr_we,
  input  logic [SEL_W-1:0]            dr_sel,
  input  logic [WORD_W-1:0]           dr_wdata,
  output logic                        dr_err,
  input  logic                        wb_we,
  input  logic [SEL_W-1:0]            wb_sel,
  input  logic [ACC_W-1:0]            wb_wdata,
  input  logic [NUM_ALU_RD*SEL_W-1:0] alu_sel,
  output logic [NUM_ALU_RD*ACC_W-1:0] alu_rdata
);
  logic bus_ok, dr_ok;
  logic bus_go, dr_go, bus_rd_go;
  logic [NUM_ACC*ACC_W-1:0] acc_flat;

  acc_access_ctl #(.SEL_W(SEL_W), .RESTRICT_FROM(2), .DR_TARGET(2)) u_ctl (
    .bus_sel(bus_sel), .bus_part(bus_part), .special_en(special_en),
    .dr_sel(dr_sel), .bus_ok(bus_ok), .dr_ok(dr_ok)
  );

  assign bus_go    = bus_we && bus_ok;
  assign bus_rd_go = bus_re && bus_ok;
  assign dr_go     = dr_we && dr_ok;
  assign bus_err   = (bus_we || bus_re) && !bus_ok;
  assign dr_err    = dr_we && !dr_ok;

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_slot
    acc_slot #(.IDX(i), .SEL_W(SEL_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wb_we(wb_we), .wb_sel(wb_sel), .wb_wdata(wb_wdata),
      .pm_we(pm_we), .pm_sel(pm_sel), .pm_wdata(pm_wdata),
      .dr_go(dr_go), .dr_sel(dr_sel), .dr_wdata(dr_wdata),
      .bus_go(bus_go), .bus_sel(bus_sel), .bus_part(bus_part), .bus_wdata(bus_wdata),
      .q(acc_flat[i*ACC_W +: ACC_W])
    );
  end

  acc_read_mux #(.NUM_ACC(NUM_ACC), .SEL_W(SEL_W)) u_bus_rd (
    .acc_flat(acc_flat), .sel(bus_sel), .part(bus_part), .en(bus_rd_go), .rdata(bus_rdata)
  );

  assign pm_rdata = acc_flat[pm_rsel*ACC_W +: ACC_W];

  for (genvar k = 0; k < NUM_ALU_RD; k++) begin : g_alu
    logic [SEL_W-1:0] s;
    assign s = alu_sel[k*SEL_W +: SEL_W];
    assign alu_rdata[k*ACC_W +: ACC_W] = acc_flat[s*ACC_W +: ACC_W];
  end
endmodule

// File: rtl/acc_regfile_chk.sv
module acc_regfile_chk
  import acc_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int SEL_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [SEL_W-1:0]         bus_sel,
  input logic [2:0]               bus_part,
  input logic                     bus_we,
  input logic                     bus_re,
  input logic [ACC_W-1:0]         bus_rdata,
  input logic                     bus_err,
  input logic                     pm_we,
  input logic [SEL_W-1:0]         pm_sel,
  input logic [ACC_W-1:0]         pm_wdata,
  input logic                     dr_we,
  input logic [SEL_W-1:0]         dr_sel,
  input logic [WORD_W-1:0]        dr_wdata,
  input logic                     dr_err,
  input logic                     wb_we,
  input logic [SEL_W-1:0]         wb_sel,
  input logic [ACC_W-1:0]         wb_wdata,
  input logic [NUM_ACC*ACC_W-1:0] acc_flat
);
  localparam logic [SEL_W-1:0] SEL_C = SEL_W'(2);

  function automatic acc_t pick(logic [NUM_ACC*ACC_W-1:0] f, logic [SEL_W-1:0] s);
    return f[s*ACC_W +: ACC_W];
  endfunction

  logic bus_wr_ok, dr_wr_ok;
  logic other_on_bus, other_on_dr, other_on_c, wb_on_pm;
  acc_t dr_expect;

  assign bus_wr_ok    = bus_we && !bus_err;
  assign dr_wr_ok     = dr_we && !dr_err;
  assign other_on_bus = (wb_we && wb_sel == bus_sel) || (pm_we && pm_sel == bus_sel) ||
                        (dr_wr_ok && bus_sel == SEL_C);
  assign other_on_dr  = (wb_we && wb_sel == dr_sel) || (pm_we && pm_sel == dr_sel) ||
                        (bus_wr_ok && bus_sel == dr_sel);
  assign other_on_c   = (wb_we && wb_sel == SEL_C) || (pm_we && pm_sel == SEL_C);
  assign wb_on_pm     = wb_we && (wb_sel == pm_sel);
  assign dr_expect    = {{EXT_W{dr_wdata[WORD_W-1]}}, dr_wdata, {WORD_W{1'b0}}};

  AST_WB_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |=> pick(acc_flat, $past(wb_sel)) == $past(wb_wdata)); // R11

  AST_PM_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_we && !wb_on_pm) |=> pick(acc_flat, $past(pm_sel)) == $past(pm_wdata)); // R8

  AST_DR_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_wr_ok && !other_on_c) |=> pick(acc_flat, SEL_C) == $past(dr_expect)); // R10

  AST_DR_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_err && !other_on_dr) |=> pick(acc_flat, $past(dr_sel)) == $past(pick(acc_flat, dr_sel))); // R10

  AST_BUS_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_err && !other_on_bus) |=> pick(acc_flat, $past(bus_sel)) == $past(pick(acc_flat, bus_sel))); // R7

  AST_BUS_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_err) |-> bus_rdata == '0); // R6

  AST_AB_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_we || bus_re) && bus_sel < SEL_C && bus_part <= 3'd5) |-> !bus_err); // R7
endmodule

bind acc_regfile acc_regfile_chk #(.NUM_ACC(NUM_ACC), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/acc_regfile_test.sv
`timescale 1ns/1ps
module acc_regfile_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        special_en = 0;
  logic [1:0]  bus_sel = 0;
  logic [2:0]  bus_part = 0;
  logic        bus_we = 0, bus_re = 0;
  logic [35:0] bus_wdata = 0;
  logic [35:0] bus_rdata;
  logic        bus_err;
  logic        pm_we = 0;
  logic [1:0]  pm_sel = 0, pm_rsel = 0;
  logic [35:0] pm_wdata = 0, pm_rdata;
  logic        dr_we = 0;
  logic [1:0]  dr_sel = 0;
  logic [15:0] dr_wdata = 0;
  logic        dr_err;
  logic        wb_we = 0;
  logic [1:0]  wb_sel = 0;
  logic [35:0] wb_wdata = 0;
  logic [3:0]  alu_sel = 0;
  logic [71:0] alu_rdata;

  int checks = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acc_regfile uut (.*);

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_we = 0; bus_re = 0; pm_we = 0; dr_we = 0; wb_we = 0;
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [2:0] p, input logic [35:0] d);
    @(negedge clk);
    bus_sel = s; bus_part = p; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic bus_rd(input logic [1:0] s, input logic [2:0] p, output logic [35:0] d, output logic e);
    bus_sel = s; bus_part = p; bus_re = 1;
    #1;
    d = bus_rdata; e = bus_err;
    bus_re = 0;
    #1;
  endtask

  task automatic chk_full(input string tag, input logic [1:0] s, input logic [35:0] exp);
    logic [35:0] d; logic e;
    bus_rd(s, 3'd4, d, e);
    chk(tag, d, exp);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) chk_full("R1 reset value", i[1:0], 36'h0);
  endtask

  task automatic t_full_long();
    logic [35:0] d; logic e;
    bus_wr(2'd0, 3'd4, 36'h9_1234_5678);
    chk_full("R2 full write", 2'd0, 36'h9_1234_5678);
    bus_wr(2'd1, 3'd3, 36'h0_8000_0001);
    chk_full("R2 long write sign-extends", 2'd1, 36'hF_8000_0001);
    bus_rd(2'd1, 3'd3, d, e);
    chk("R5 long read", d, 36'hF_8000_0001);
  endtask

  task automatic t_word_byte();
    logic [35:0] d; logic e;
    bus_wr(2'd0, 3'd1, 36'h0_0000_8001);
    chk_full("R3 word write", 2'd0, 36'hF_8001_0000);
    bus_rd(2'd0, 3'd1, d, e);
    chk("R5 word read", d, 36'hF_FFFF_8001);
    bus_wr(2'd1, 3'd5, 36'h0_0000_007F);
    chk_full("R3 byte write", 2'd1, 36'h0_007F_0000);
    bus_rd(2'd1, 3'd5, d, e);
    chk("R5 byte read", d, 36'h0_0000_007F);
  endtask

  task automatic t_ext_lo();
    logic [35:0] d; logic e;
    bus_wr(2'd0, 3'd0, 36'h0_0000_0005);
    chk_full("R4 ext write", 2'd0, 36'h5_8001_0000);
    bus_wr(2'd0, 3'd2, 36'h0_0000_BEEF);
    chk_full("R4 lower word write", 2'd0, 36'h5_8001_BEEF);
    bus_rd(2'd0, 3'd0, d, e);
    chk("R5 ext read", d, 36'h0_0000_0005);
    bus_rd(2'd0, 3'd2, d, e);
    chk("R5 lower word read", d, 36'h0_0000_BEEF);
  endtask

  task automatic t_invalid();
    logic [35:0] d; logic e;
    @(negedge clk);
    bus_sel = 2'd0; bus_part = 3'd6; bus_wdata = 36'h0; bus_we = 1;
    #1;
    chk("R6 err on bad code write", {35'h0, bus_err}, 36'h1);
    @(negedge clk);
    idle();
    chk_full("R6 bad code leaves A", 2'd0, 36'h5_8001_BEEF);
    bus_rd(2'd0, 3'd7, d, e);
    chk("R6 bad code read data", d, 36'h0);
    chk("R6 bad code read err", {35'h0, e}, 36'h1);
  endtask

  task automatic t_restrict();
    logic [35:0] d; logic e;
    special_en = 0;
    @(negedge clk);
    bus_sel = 2'd2; bus_part = 3'd2; bus_wdata = 36'h1111; bus_we = 1;
    #1;
    chk("R7 C lower refused err", {35'h0, bus_err}, 36'h1);
    @(negedge clk);
    idle();
    chk_full("R7 C unchanged", 2'd2, 36'h0);
    bus_rd(2'd3, 3'd0, d, e);
    chk("R7 D ext read refused", {d[34:0], e}, 36'h1);
    bus_wr(2'd2, 3'd1, 36'h1234);
    chk_full("R7 C word allowed", 2'd2, 36'h0_1234_0000);
    special_en = 1;
    bus_wr(2'd2, 3'd2, 36'h1111);
    chk_full("R7 C lower with enable", 2'd2, 36'h0_1234_1111);
    special_en = 0;
  endtask

  task automatic t_pm();
    @(negedge clk);
    pm_we = 1; pm_sel = 2'd3; pm_wdata = 36'hA_AAAA_5555;
    alu_sel = 4'b0011; pm_rsel = 2'd3;
    #1;
    chk("R9 alu sees old value", alu_rdata[35:0], 36'h0);
    chk("R9 second port reads A", alu_rdata[71:36], 36'h5_8001_BEEF);
    @(negedge clk);
    idle();
    #1;
    chk("R8 pm load whole", pm_rdata, 36'hA_AAAA_5555);
    chk("R9 alu sees new value", alu_rdata[35:0], 36'hA_AAAA_5555);
  endtask

  task automatic t_dr();
    @(negedge clk);
    dr_we = 1; dr_sel = 2'd2; dr_wdata = 16'hFFFE;
    #1;
    chk("R10 C accepted no err", {35'h0, dr_err}, 36'h0);
    @(negedge clk);
    dr_sel = 2'd1; dr_wdata = 16'h1234;
    #1;
    chk("R10 B refused err", {35'h0, dr_err}, 36'h1);
    @(negedge clk);
    idle();
    chk_full("R10 C word format", 2'd2, 36'hF_FFFE_0000);
    chk_full("R10 B unchanged", 2'd1, 36'h0_007F_0000);
  endtask

  task automatic t_prio();
    @(negedge clk);
    wb_we = 1; wb_sel = 2'd0; wb_wdata = 36'h1;
    pm_we = 1; pm_sel = 2'd0; pm_wdata = 36'h2;
    @(negedge clk);
    idle();
    chk_full("R11 wb beats pm", 2'd0, 36'h1);
    @(negedge clk);
    pm_we = 1; pm_sel = 2'd1; pm_wdata = 36'h3;
    bus_we = 1; bus_sel = 2'd1; bus_part = 3'd4; bus_wdata = 36'h4;
    @(negedge clk);
    idle();
    chk_full("R11 pm beats bus", 2'd1, 36'h3);
    @(negedge clk);
    dr_we = 1; dr_sel = 2'd2; dr_wdata = 16'h0001;
    bus_we = 1; bus_sel = 2'd2; bus_part = 3'd4; bus_wdata = 36'h5;
    @(negedge clk);
    idle();
    chk_full("R11 dr beats bus", 2'd2, 36'h0_0001_0000);
    @(negedge clk);
    wb_we = 1; wb_sel = 2'd3; wb_wdata = 36'h7;
    pm_we = 1; pm_sel = 2'd2; pm_wdata = 36'h8;
    @(negedge clk);
    idle();
    chk_full("R11 different targets D", 2'd3, 36'h7);
    chk_full("R11 different targets C", 2'd2, 36'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_long();
    t_word_byte();
    t_ext_lo();
    t_invalid();
    t_restrict();
    t_pm();
    t_dr();
    t_prio();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule